// File: doc/BRIEF.md
# Codec Control Register Bank

This block is the configuration store for a voice codec's serial port and code unit. A host writes bytes over a plain synchronous address/data bus. There are four locations: two control registers, one register for the C channel byte and one for the D channel byte. Reads are combinational from the current address, so the host can verify each write. Every stored bit is also brought out as its own configuration output.

Two things return the bank to its default state. The first is an active-low hardware reset. The second is a software reset bit in the first control register. Once that bit is set, it holds every other register at its default value and keeps itself set until the host writes it back to zero. A three-bit clock-select field in the second control register is decoded into a port mode, an input clock rate, a bit clock rate and a divide ratio.

Top module: `codec_cfg_regs`

## Requirements
- R1: After hardware reset (rstN low), address 03h reads 00h, 04h reads 02h, and 05h and 06h read 00h.
- R2: A write to 03h, 04h, 05h or 06h is read back at that address from the next cycle. Any other address reads 00h, and writes to other addresses change nothing.
- R3: Bit 2 of address 03h is reserved. It always reads 0, whatever is written to it.
- R4: Writing address 03h with bit 3 set starts a software reset. From the next cycle, 03h reads 08h, 04h reads 02h, 05h and 06h read 00h, and softRstActive is 1.
- R5: While the software reset is active, writes to 04h, 05h and 06h are ignored.
- R6: The software reset ends only when 03h is written with bit 3 clear, or on a hardware reset. That write leaves 03h at 00h, and later writes take effect normally.
- R7: The fields of address 03h drive outputs at these bit positions: 7 pdAll, 6 pdEar, 5 txSlotSel, 4 rxSlotSel, 3 softRstActive, 1 txMute, 0 rxMute.
- R8: The fields of address 04h drive outputs at these bit positions: 7 cEnable, 6 dEnable, 5 dRate8k, 4 aLawSel, 3 signMagSel. Bits 2:0 are the clock-select code.
- R9: Clock-select code 111 gives busMode=1, inClkKhz=4096, bitClkKhz=0 and clkDiv=1.
- R10: Clock-select codes 100 and 101 give busMode=0 and inClkKhz=4096. Code 100 gives bitClkKhz=128 with clkDiv=32, and code 101 gives bitClkKhz=256 with clkDiv=16.
- R11: Clock-select codes 000, 001, 010 and 011 give busMode=0 and clkDiv=1, with bitClkKhz equal to inClkKhz. The rates for these codes are 512, 1536, 2048 and 4096 kHz.
- R12: cChanData and dChanData present the contents of 05h and 06h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low |
| wrEn | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr |
| pdAll | output | 1 | Power down filter and code unit |
| pdEar | output | 1 | Power down ear driver |
| txSlotSel | output | 1 | Transmit slot select |
| rxSlotSel | output | 1 | Receive slot select |
| softRstActive | output | 1 | Software reset in force |
| txMute | output | 1 | Transmit mute |
| rxMute | output | 1 | Receive mute |
| cEnable | output | 1 | Drive C channel slot |
| dEnable | output | 1 | Drive D channel slot |
| dRate8k | output | 1 | D channel at 8 kb/s |
| aLawSel | output | 1 | A-law companding |
| signMagSel | output | 1 | Sign-magnitude code assignment |
| busMode | output | 1 | Bus (framed) port mode |
| inClkKhz | output | 13 | Expected input clock in kHz |
| bitClkKhz | output | 13 | Bit clock in kHz, 0 in bus mode |
| clkDiv | output | 6 | Input-to-bit clock divide ratio |
| cChanData | output | 8 | C channel register |
| dChanData | output | 8 | D channel register |

## Verification
A stuck or wrongly cleared software reset flag shows up in the cycle after the write. The flag output is wrong, 03h reads back wrongly, and the next write to 04h–06h either sticks when it should be blocked or is blocked when it should stick. A corrupted register reaches its field outputs and rdData one cycle after the write, because the reads are combinational. A wrong decode entry shows on the clock outputs as soon as the select code is written. For that reason, all eight codes are swept with an expected rate and ratio for each.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;
  localparam int DW = 8;
  localparam logic [DW-1:0] CTL1_DEF = 8'h00;
  localparam logic [DW-1:0] CTL2_DEF = 8'h02;
  localparam logic [DW-1:0] CTL1_RSV = 8'h04;
  localparam int SRST_BIT = 3;
  localparam int KHZ_W = 13;
  localparam int DIV_W = 6;

  typedef enum logic [2:0] {RD_NONE, RD_CTL1, RD_CTL2, RD_CCH, RD_DCH} rdSel_e;

  typedef struct packed {
    logic   wrCtl1;
    logic   wrCtl2;
    logic   wrCch;
    logic   wrDch;
    rdSel_e rdSel;
  } strb_t;
endpackage

// File: rtl/codec_cfg_ctrl.sv
module codec_cfg_ctrl
  import codec_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL1_ADDR = 'h03,
  parameter logic [ADDR_W-1:0] CTL2_ADDR = 'h04,
  parameter logic [ADDR_W-1:0] CCH_ADDR  = 'h05,
  parameter logic [ADDR_W-1:0] DCH_ADDR  = 'h06
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strb_t             strb
);
  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (addr == CTL1_ADDR) strb.rdSel = RD_CTL1;
    else if (addr == CTL2_ADDR) strb.rdSel = RD_CTL2;
    else if (addr == CCH_ADDR) strb.rdSel = RD_CCH;
    else if (addr == DCH_ADDR) strb.rdSel = RD_DCH;
    strb.wrCtl1 = wrEn && (strb.rdSel == RD_CTL1);
    strb.wrCtl2 = wrEn && (strb.rdSel == RD_CTL2);
    strb.wrCch  = wrEn && (strb.rdSel == RD_CCH);
    strb.wrDch  = wrEn && (strb.rdSel == RD_DCH);
  end

  // R2: at most one register is written per cycle
  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtl1, strb.wrCtl2, strb.wrCch, strb.wrDch}));
  // R2: no write strobe without wrEn
  assert_write_needs_en_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strb.wrCtl1 || strb.wrCtl2 || strb.wrCch || strb.wrDch));
endmodule

// File: rtl/codec_cfg_clkdec.sv
module codec_cfg_clkdec
  import codec_cfg_pkg::*;
(
  input  logic [2:0]       clkSel,
  output logic             busMode,
  output logic [KHZ_W-1:0] inClkKhz,
  output logic [KHZ_W-1:0] bitClkKhz,
  output logic [DIV_W-1:0] clkDiv
);
  always_comb begin
    busMode   = 1'b0;
    inClkKhz  = KHZ_W'(4096);
    bitClkKhz = KHZ_W'(4096);
    clkDiv    = DIV_W'(1);
    unique case (clkSel)
      3'b111: begin busMode = 1'b1; bitClkKhz = '0; end
      3'b100: begin bitClkKhz = KHZ_W'(128); clkDiv = DIV_W'(32); end
      3'b101: begin bitClkKhz = KHZ_W'(256); clkDiv = DIV_W'(16); end
      3'b110: ;
      3'b000: begin inClkKhz = KHZ_W'(512);  bitClkKhz = KHZ_W'(512);  end
      3'b001: begin inClkKhz = KHZ_W'(1536); bitClkKhz = KHZ_W'(1536); end
      3'b010: begin inClkKhz = KHZ_W'(2048); bitClkKhz = KHZ_W'(2048); end
      3'b011: ;
      default: ;
    endcase
  end

  always_comb begin
    // R10: divided modes always run from the 4096 kHz input
    assert_div_from_4096_R10: assert (clkDiv == DIV_W'(1) || (inClkKhz == KHZ_W'(4096) && !busMode));
    // R9: bus mode carries no strobe bit clock
    assert_bus_no_bitclk_R9: assert (!busMode || (bitClkKhz == '0 && clkDiv == DIV_W'(1)));
  end
endmodule

// File: rtl/codec_cfg_dp.sv
module codec_cfg_dp
  import codec_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strb_t         strb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] ctl1Q,
  output logic [DW-1:0] ctl2Q,
  output logic [DW-1:0] cchQ,
  output logic [DW-1:0] dchQ,
  output logic [DW-1:0] rdData
);
  logic softOn;
  assign softOn = ctl1Q[SRST_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl1Q <= CTL1_DEF;
      ctl2Q <= CTL2_DEF;
      cchQ  <= '0;
      dchQ  <= '0;
    end else if (strb.wrCtl1 && wrData[SRST_BIT]) begin
      ctl1Q <= CTL1_DEF | (DW'(1) << SRST_BIT);
      ctl2Q <= CTL2_DEF;
      cchQ  <= '0;
      dchQ  <= '0;
    end else if (softOn) begin
      if (strb.wrCtl1) ctl1Q <= CTL1_DEF;
    end else begin
      if (strb.wrCtl1) ctl1Q <= wrData & ~CTL1_RSV;
      if (strb.wrCtl2) ctl2Q <= wrData;
      if (strb.wrCch)  cchQ  <= wrData;
      if (strb.wrDch)  dchQ  <= wrData;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_CTL1: rdData = ctl1Q;
      RD_CTL2: rdData = ctl2Q;
      RD_CCH:  rdData = cchQ;
      RD_DCH:  rdData = dchQ;
      default: rdData = '0;
    endcase
  end

  // R5: while soft reset holds, the other registers stay at defaults
  assert_soft_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    softOn |=> (ctl2Q == CTL2_DEF && cchQ == '0 && dchQ == '0));
  // R4: setting the reset bit clears the bank next cycle
  assert_soft_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCtl1 && wrData[SRST_BIT]) |=> (softOn && ctl2Q == CTL2_DEF && cchQ == '0));
  // R6: the flag only falls through a write to control register 1
  assert_soft_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (softOn && !strb.wrCtl1) |=> softOn);
  // R2: an unblocked C channel write lands
  assert_cch_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCch && !softOn && !strb.wrCtl1) |=> (cchQ == $past(wrData)));
  // R3: the reserved bit never holds a one
  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl1Q & CTL1_RSV) == '0);
endmodule

// File: rtl/codec_cfg_regs.sv
module codec_cfg_regs
  import codec_cfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              pdAll,
  output logic              pdEar,
  output logic              txSlotSel,
  output logic              rxSlotSel,
  output logic              softRstActive,
  output logic              txMute,
  output logic              rxMute,
  output logic              cEnable,
  output logic              dEnable,
  output logic              dRate8k,
  output logic              aLawSel,
  output logic              signMagSel,
  output logic              busMode,
  output logic [12:0]       inClkKhz,
  output logic [12:0]       bitClkKhz,
  output logic [5:0]        clkDiv,
  output logic [7:0]        cChanData,
  output logic [7:0]        dChanData
);
  strb_t strb;
  logic [DW-1:0] ctl1Q, ctl2Q;

  codec_cfg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .strb(strb)
  );

  codec_cfg_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .ctl1Q(ctl1Q), .ctl2Q(ctl2Q), .cchQ(cChanData), .dchQ(dChanData),
    .rdData(rdData)
  );

  codec_cfg_clkdec clkdec_i (
    .clkSel(ctl2Q[2:0]), .busMode(busMode), .inClkKhz(inClkKhz),
    .bitClkKhz(bitClkKhz), .clkDiv(clkDiv)
  );

  assign pdAll         = ctl1Q[7];
  assign pdEar         = ctl1Q[6];
  assign txSlotSel     = ctl1Q[5];
  assign rxSlotSel     = ctl1Q[4];
  assign softRstActive = ctl1Q[3];
  assign txMute        = ctl1Q[1];
  assign rxMute        = ctl1Q[0];
  assign cEnable       = ctl2Q[7];
  assign dEnable       = ctl2Q[6];
  assign dRate8k       = ctl2Q[5];
  assign aLawSel       = ctl2Q[4];
  assign signMagSel    = ctl2Q[3];
endmodule

// File: tb/codec_cfg_regs_tb_top.sv
module codec_cfg_regs_tb_top;
  logic clk = 0, rstN = 0, wrEn = 0;
  logic [7:0] addr = 0, wrData = 0;
  logic [7:0] rdData, cChanData, dChanData;
  logic pdAll, pdEar, txSlotSel, rxSlotSel, softRstActive, txMute, rxMute;
  logic cEnable, dEnable, dRate8k, aLawSel, signMagSel, busMode;
  logic [12:0] inClkKhz, bitClkKhz;
  logic [5:0] clkDiv;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  codec_cfg_regs dut_i (.*);

  // {address, write data, expected read}
  localparam logic [23:0] VEC [0:7] = '{
    24'h03F7F3, 24'h045B5B, 24'h05A5A5, 24'h063C3C,
    24'h07FF00, 24'h021100, 24'h030303, 24'h04FCFC
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(req, rdData, exp);
  endtask

  task automatic expClk(input logic [2:0] c, output logic bm, output int inK,
                        output int bitK, output int dv);
    bm = 0; inK = 4096; bitK = 4096; dv = 1;
    case (c)
      3'd7: begin bm = 1; bitK = 0; end
      3'd4: begin bitK = 128; dv = 32; end
      3'd5: begin bitK = 256; dv = 16; end
      3'd0: begin inK = 512;  bitK = 512;  end
      3'd1: begin inK = 1536; bitK = 1536; end
      3'd2: begin inK = 2048; bitK = 2048; end
      default: ;
    endcase
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic bm; int inK, bitK, dv;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd("R1 ctl1", 8'h03, 8'h00); rd("R1 ctl2", 8'h04, 8'h02);
    rd("R1 cch", 8'h05, 8'h00);  rd("R1 dch", 8'h06, 8'h00);
    @(negedge clk); rstN = 1;
    // R11 default code 010
    chk("R11 default bitclk", bitClkKhz, 2048);

    // R2 R3 vector table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd($sformatf("R2/R3 vec%0d", i), VEC[i][23:16], VEC[i][7:0]);
    end
    chk("R12 cChanData", cChanData, 8'hA5);
    chk("R12 dChanData", dChanData, 8'h3C);

    // R7 field positions, 03h = A2
    wr(8'h03, 8'hA2);
    chk("R7 fields", {pdAll, pdEar, txSlotSel, rxSlotSel, softRstActive, txMute, rxMute},
        7'b1010010);
    wr(8'h03, 8'h51);
    chk("R7 fields b", {pdAll, pdEar, txSlotSel, rxSlotSel, softRstActive, txMute, rxMute},
        7'b0101001);

    // R8 R9 R10 R11 clock sweep with upper bits 10101
    for (int c = 0; c < 8; c++) begin
      wr(8'h04, {5'b10101, 3'(c)});
      expClk(3'(c), bm, inK, bitK, dv);
      chk("R8 fields", {cEnable, dEnable, dRate8k, aLawSel, signMagSel}, 5'b10101);
      chk($sformatf("R9/R10/R11 code%0d bus", c), busMode, bm);
      chk($sformatf("R9/R10/R11 code%0d in", c), inClkKhz, inK);
      chk($sformatf("R9/R10/R11 code%0d bit", c), bitClkKhz, bitK);
      chk($sformatf("R9/R10/R11 code%0d div", c), clkDiv, dv);
    end

    // R4 soft reset entry
    wr(8'h05, 8'h77); wr(8'h06, 8'h11);
    wr(8'h03, 8'h28);
    chk("R4 flag", softRstActive, 1);
    chk("R4 txSlotSel", txSlotSel, 0);
    rd("R4 ctl1", 8'h03, 8'h08); rd("R4 ctl2", 8'h04, 8'h02);
    rd("R4 cch", 8'h05, 8'h00);  rd("R4 dch", 8'h06, 8'h00);
    // R5 writes ignored
    wr(8'h04, 8'hFF); wr(8'h05, 8'h99); wr(8'h06, 8'h66);
    rd("R5 ctl2", 8'h04, 8'h02); rd("R5 cch", 8'h05, 8'h00);
    rd("R5 dch", 8'h06, 8'h00);
    chk("R5 clkdiv", clkDiv, 1);
    // R6 still set after a rewrite with bit3 high, then release
    wr(8'h03, 8'hFF);
    rd("R6 held", 8'h03, 8'h08);
    wr(8'h03, 8'hF0);
    rd("R6 release", 8'h03, 8'h00);
    chk("R6 flag low", softRstActive, 0);
    wr(8'h04, 8'hFF);
    rd("R6 write works", 8'h04, 8'hFF);
    // R6 hardware reset clears soft reset
    wr(8'h03, 8'h08);
    @(negedge clk); rstN = 0; #1;
    chk("R6 hw clears flag", softRstActive, 0);
    rd("R1 hw ctl2", 8'h04, 8'h02);
    @(negedge clk); rstN = 1;
    wr(8'h05, 8'h5A);
    rd("R2 after hw", 8'h05, 8'h5A);
    summary();
  end
endmodule